// File: doc/BRIEF.md
# Hot-Plug Slot Register Controller

This block holds the slot control and slot status registers of a hot-plug capable downstream port. Configuration software reaches them through a one-word write/read port with byte enables. The physical slot reports its own events on three inputs: an attention-button pulse, a hot-add pulse and a populated level. The block turns these inputs and the software writes into status bits. It raises a hot-plug interrupt in one of two forms. When message signalling is off, it drives a level INTx. When message signalling is on, it drives a one-cycle message pulse that carries a vector number.

Each write to the control register counts as one command. The block carries out the command in the same cycle and then sets command-completed. One control bit is a command strobe and always reads as 0. Writing 1 to it flips the interlock-engaged status. A control write can also turn off an occupied slot's power controller and its power indicator together. In that case the block pulses `detach` for one cycle, drops presence-detect state and flags a presence change. The surrounding port logic removes the device when it sees that pulse.

Top module: `hp_slot_ctrl`

## Requirements
- R1: Synchronous reset behaviour. Every enable bit is cleared. The attention indicator is set to off. The interlock, button, presence-changed and command-completed status bits are cleared. Presence-detect state is loaded from `slot_populated`. With power control present, the power controller bit [10] is set to 1 (off) and the power indicator is set to off when the slot is empty. When the slot is populated, bit [10] is 0 and the power indicator is on. An empty slot therefore resets control to 0x07C0, and a populated slot to 0x01C0.
- R2: The status event bits are write-1-to-clear, each qualified by its byte enable. Button-pressed is [0], presence-changed is [3] and command-completed is [4]; all three sit in byte 0. Presence-detect state [6] and interlock-engaged [7] are read-only. If a hardware set and a software clear hit the same bit in the same cycle, the bit ends up set.
- R3: Every control write with a nonzero byte enable sets command-completed.
- R4: A control write of 1 to bit [11] with byte enable 1 set flips interlock-engaged. Bit [11] always reads as 0.
- R5: A control write with byte enable 1 set can detach the slot. The condition is that presence-detect state is 1, the written bit [10] is 1, and the written power indicator [9:8] is 11 (off). The block then pulses `detach` once, clears presence-detect state and sets presence-changed. If any part of the condition fails, no detach occurs.
- R6: The pending condition is true when hot-plug interrupt enable [5] is 1 and (status AND control AND 0x0019) is nonzero. The three per-event enables are button [0], presence-changed [3] and command-completed [4]. With `msi_en` and `msix_en` both low, `intx` follows the pending condition one cycle later and falls after a status clear that removes it. Pending never holds while [5] is 0.
- R7: While `msi_en` or `msix_en` is high, `intx` stays low. Each time pending goes from false to true, `msg_pulse` is high for exactly one cycle and `msg_vec` carries `msg_vector`. A fall of pending sends no message.
- R8: Setting an event bit that is already set causes no new message.
- R9: `evt_btn` sets button-pressed. `evt_add` sets presence-detect state, presence-changed and button-pressed together.
- R10: `cfg_sel`=0 selects control and `cfg_sel`=1 selects status. The writable control bits are [0], [3], [4], [5], attention indicator [7:6], power indicator [9:8] and [10]. Each of these changes only when its byte enable is set. A write with all byte enables low does nothing. `cfg_rdata` shows the selected register combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 1 | 0 selects control, 1 selects status |
| cfg_be | input | 2 | Byte enables for the write |
| cfg_wdata | input | 16 | Write data |
| cfg_rdata | output | 16 | Selected register contents |
| evt_btn | input | 1 | Attention-button pulse from the slot |
| evt_add | input | 1 | Hot-add pulse from the slot |
| slot_populated | input | 1 | Slot occupancy, sampled during reset |
| msi_en | input | 1 | Message interrupts enabled |
| msix_en | input | 1 | Extended message interrupts enabled |
| msg_vector | input | VEC_W | Vector number for message interrupts |
| intx | output | 1 | Level interrupt |
| msg_pulse | output | 1 | One-cycle message interrupt request |
| msg_vec | output | VEC_W | Vector sent with the message pulse |
| detach | output | 1 | One-cycle request to remove the device |

## Verification
The properties assume that a hot-add pulse never arrives in the same cycle as a control write. A detach and a re-insertion landing together would otherwise leave presence-detect state with no defined order. The properties also assume that `msi_en` and `msix_en` do not change in the same cycle that pending rises. The stimulus meets both assumptions: it applies one slot event or one register write per operation, then waits two idle cycles before it checks. It changes the interrupt-mode inputs only while no status bit is pending.

// File: rtl/hp_slot_pkg.sv
package hp_slot_pkg;

    localparam int REG_W = 16;
    localparam int BE_W  = REG_W / 8;

    typedef enum logic {
        SEL_CTL = 1'b0,
        SEL_STS = 1'b1
    } reg_sel_e;

    // control field positions
    localparam int C_BTN_EN  = 0;
    localparam int C_PCHG_EN = 3;
    localparam int C_CMD_EN  = 4;
    localparam int C_HPI_EN  = 5;
    localparam int C_ATN_LO  = 6;
    localparam int C_PIND_LO = 8;
    localparam int C_PWR_OFF = 10;
    localparam int C_LOCK    = 11;

    // status field positions, events aligned with their enables
    localparam int S_BTN  = 0;
    localparam int S_PCHG = 3;
    localparam int S_CMD  = 4;
    localparam int S_PRES = 6;
    localparam int S_LOCK = 7;

    localparam logic [1:0] IND_ON  = 2'b01;
    localparam logic [1:0] IND_OFF = 2'b11;

    localparam logic [REG_W-1:0] EVT_MASK  = 16'h0019;
    localparam logic [REG_W-1:0] CTL_WMASK = 16'h07F9;

    typedef struct packed {
        logic btn;
        logic pchg;
        logic cmd;
    } evt_set_t;

    function automatic logic [REG_W-1:0] be_expand(input logic [BE_W-1:0] be);
        logic [REG_W-1:0] m;
        for (int i = 0; i < BE_W; i++) begin
            m[i*8 +: 8] = {8{be[i]}};
        end
        return m;
    endfunction

endpackage

// File: rtl/hp_slot_ctl.sv
module hp_slot_ctl
    import hp_slot_pkg::*;
#(
    parameter bit HAS_PWR_CTL = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    input  logic [BE_W-1:0]  be,
    input  logic             populated,
    input  logic             pres_state,
    output logic [REG_W-1:0] ctl_q,
    output logic             lock_toggle,
    output logic             detach_req,
    output logic             detach_o
);

    localparam logic [REG_W-1:0] WMASK =
        HAS_PWR_CTL ? CTL_WMASK : (CTL_WMASK & ~(16'd1 << C_PWR_OFF));

    logic [REG_W-1:0] rst_val;
    logic [REG_W-1:0] bmask;
    logic [REG_W-1:0] ctl_d;

    generate
        if (HAS_PWR_CTL) begin : g_pwr
            always_comb begin
                rst_val                 = '0;
                rst_val[C_ATN_LO +: 2]  = IND_OFF;
                rst_val[C_PIND_LO +: 2] = populated ? IND_ON : IND_OFF;
                rst_val[C_PWR_OFF]      = ~populated;
            end
        end else begin : g_nopwr
            always_comb begin
                rst_val                = '0;
                rst_val[C_ATN_LO +: 2] = IND_OFF;
            end
        end
    endgenerate

    always_comb begin
        bmask       = be_expand(be) & WMASK;
        ctl_d       = wr_en ? ((ctl_q & ~bmask) | (wdata & bmask)) : ctl_q;
        lock_toggle = wr_en & be[C_LOCK/8] & wdata[C_LOCK];
        detach_req  = wr_en & be[C_PWR_OFF/8] & pres_state & wdata[C_PWR_OFF]
                    & (wdata[C_PIND_LO +: 2] == IND_OFF);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q    <= rst_val;
            detach_o <= 1'b0;
        end else begin
            ctl_q    <= ctl_d;
            detach_o <= detach_req;
        end
    end

endmodule

// File: rtl/hp_slot_sts.sv
module hp_slot_sts
    import hp_slot_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             populated,
    input  logic             w1c_en,
    input  logic [REG_W-1:0] w1c_data,
    input  logic [BE_W-1:0]  be,
    input  evt_set_t         set_evt,
    input  logic             set_pres,
    input  logic             clr_pres,
    input  logic             lock_toggle,
    output logic [REG_W-1:0] sts_q
);

    logic [REG_W-1:0] clr_mask;
    logic [REG_W-1:0] set_mask;
    logic [REG_W-1:0] sts_d;

    always_comb begin
        clr_mask         = w1c_en ? (w1c_data & be_expand(be) & EVT_MASK) : '0;
        set_mask         = '0;
        set_mask[S_BTN]  = set_evt.btn;
        set_mask[S_PCHG] = set_evt.pchg;
        set_mask[S_CMD]  = set_evt.cmd;
        // set after clear: hardware wins a collision
        sts_d = (sts_q & ~clr_mask) | set_mask;
        if (clr_pres) begin
            sts_d[S_PRES] = 1'b0;
        end else if (set_pres) begin
            sts_d[S_PRES] = 1'b1;
        end
        sts_d[S_LOCK] = sts_q[S_LOCK] ^ lock_toggle;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sts_q         <= '0;
            sts_q[S_PRES] <= populated;
        end else begin
            sts_q <= sts_d;
        end
    end

endmodule

// File: rtl/hp_slot_irq.sv
module hp_slot_irq
    import hp_slot_pkg::*;
#(
    parameter int VEC_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [REG_W-1:0] ctl_q,
    input  logic [REG_W-1:0] sts_q,
    input  logic             msg_mode,
    input  logic [VEC_W-1:0] vector,
    output logic             intx,
    output logic             msg_pulse,
    output logic [VEC_W-1:0] msg_vec
);

    logic pend_now;
    logic pend_q;
    logic rise;

    always_comb begin
        pend_now = ctl_q[C_HPI_EN] & (|(sts_q & ctl_q & EVT_MASK));
        rise     = pend_now & ~pend_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q    <= 1'b0;
            intx      <= 1'b0;
            msg_pulse <= 1'b0;
            msg_vec   <= '0;
        end else begin
            pend_q    <= pend_now;
            intx      <= pend_now & ~msg_mode;
            msg_pulse <= rise & msg_mode;
            if (rise & msg_mode) begin
                msg_vec <= vector;
            end
        end
    end

endmodule

// File: rtl/hp_slot_ctrl.sv
module hp_slot_ctrl
    import hp_slot_pkg::*;
#(
    parameter int VEC_W       = 5,
    parameter bit HAS_PWR_CTL = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_wr,
    input  logic             cfg_sel,
    input  logic [BE_W-1:0]  cfg_be,
    input  logic [REG_W-1:0] cfg_wdata,
    output logic [REG_W-1:0] cfg_rdata,
    input  logic             evt_btn,
    input  logic             evt_add,
    input  logic             slot_populated,
    input  logic             msi_en,
    input  logic             msix_en,
    input  logic [VEC_W-1:0] msg_vector,
    output logic             intx,
    output logic             msg_pulse,
    output logic [VEC_W-1:0] msg_vec,
    output logic             detach
);

    logic [REG_W-1:0] ctl_q;
    logic [REG_W-1:0] sts_q;
    logic             wr_ctl;
    logic             wr_sts;
    logic             lock_toggle;
    logic             detach_req;
    evt_set_t         set_evt;

    always_comb begin
        wr_ctl       = cfg_wr & (reg_sel_e'(cfg_sel) == SEL_CTL) & (|cfg_be);
        wr_sts       = cfg_wr & (reg_sel_e'(cfg_sel) == SEL_STS);
        set_evt.btn  = evt_btn | evt_add;
        set_evt.pchg = evt_add | detach_req;
        set_evt.cmd  = wr_ctl;
        cfg_rdata    = (reg_sel_e'(cfg_sel) == SEL_STS) ? sts_q : ctl_q;
    end

    hp_slot_ctl #(
        .HAS_PWR_CTL(HAS_PWR_CTL)
    ) ctl_i (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_ctl),
        .wdata      (cfg_wdata),
        .be         (cfg_be),
        .populated  (slot_populated),
        .pres_state (sts_q[S_PRES]),
        .ctl_q      (ctl_q),
        .lock_toggle(lock_toggle),
        .detach_req (detach_req),
        .detach_o   (detach)
    );

    hp_slot_sts sts_i (
        .clk        (clk),
        .rst        (rst),
        .populated  (slot_populated),
        .w1c_en     (wr_sts),
        .w1c_data   (cfg_wdata),
        .be         (cfg_be),
        .set_evt    (set_evt),
        .set_pres   (evt_add),
        .clr_pres   (detach_req),
        .lock_toggle(lock_toggle),
        .sts_q      (sts_q)
    );

    hp_slot_irq #(
        .VEC_W(VEC_W)
    ) irq_i (
        .clk      (clk),
        .rst      (rst),
        .ctl_q    (ctl_q),
        .sts_q    (sts_q),
        .msg_mode (msi_en | msix_en),
        .vector   (msg_vector),
        .intx     (intx),
        .msg_pulse(msg_pulse),
        .msg_vec  (msg_vec)
    );

endmodule

// File: rtl/hp_slot_chk.sv
module hp_slot_chk
    import hp_slot_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             cfg_wr,
    input logic             cfg_sel,
    input logic [BE_W-1:0]  cfg_be,
    input logic [REG_W-1:0] cfg_wdata,
    input logic             evt_btn,
    input logic [REG_W-1:0] ctl_q,
    input logic [REG_W-1:0] sts_q,
    input logic             intx,
    input logic             msg_pulse,
    input logic             detach
);

    logic ctl_write;
    logic sts_write;

    assign ctl_write = cfg_wr && !cfg_sel && (cfg_be != '0);
    assign sts_write = cfg_wr && cfg_sel;

    // R3
    cmd_done_set_chk: assert property (@(posedge clk) disable iff (rst)
        ctl_write |=> sts_q[S_CMD]);

    // R4
    lock_flip_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_write && cfg_be[1] && cfg_wdata[C_LOCK]) |=> (sts_q[S_LOCK] != $past(sts_q[S_LOCK])));

    // R5
    detach_state_chk: assert property (@(posedge clk) disable iff (rst)
        detach |-> (!sts_q[S_PRES] && sts_q[S_PCHG]));

    // R2
    w1c_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        (sts_write && cfg_be[0] && cfg_wdata[S_CMD]) |=> !sts_q[S_CMD]);

    // R2
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (sts_write && cfg_be[0] && cfg_wdata[S_BTN] && evt_btn) |=> sts_q[S_BTN]);

    // R6
    intx_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
        intx |-> $past(ctl_q[C_HPI_EN]));

    // R7
    msg_single_chk: assert property (@(posedge clk) disable iff (rst)
        msg_pulse |=> !msg_pulse);

    // R7
    intx_msg_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(intx && msg_pulse));

endmodule

bind hp_slot_ctrl hp_slot_chk chk_i (
    .clk      (clk),
    .rst      (rst),
    .cfg_wr   (cfg_wr),
    .cfg_sel  (cfg_sel),
    .cfg_be   (cfg_be),
    .cfg_wdata(cfg_wdata),
    .evt_btn  (evt_btn),
    .ctl_q    (ctl_q),
    .sts_q    (sts_q),
    .intx     (intx),
    .msg_pulse(msg_pulse),
    .detach   (detach)
);

// File: tb/hp_slot_ctrl_tb_top.sv
`timescale 1ns/1ps
module hp_slot_ctrl_tb_top;

    localparam int VEC_W = 5;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cfg_wr = 1'b0;
    logic             cfg_sel = 1'b0;
    logic [1:0]       cfg_be = 2'b00;
    logic [15:0]      cfg_wdata = 16'h0;
    logic [15:0]      cfg_rdata;
    logic             evt_btn = 1'b0;
    logic             evt_add = 1'b0;
    logic             slot_populated = 1'b0;
    logic             msi_en = 1'b0;
    logic             msix_en = 1'b0;
    logic [VEC_W-1:0] msg_vector = 5'd19;
    logic             intx;
    logic             msg_pulse;
    logic [VEC_W-1:0] msg_vec;
    logic             detach;

    always #2.5 clk = ~clk;

    hp_slot_ctrl #(.VEC_W(VEC_W), .HAS_PWR_CTL(1'b1)) dut_i (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_be(cfg_be),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .evt_btn(evt_btn),
        .evt_add(evt_add), .slot_populated(slot_populated), .msi_en(msi_en),
        .msix_en(msix_en), .msg_vector(msg_vector), .intx(intx),
        .msg_pulse(msg_pulse), .msg_vec(msg_vec), .detach(detach)
    );

    // scoreboard items: kind 0 register read, 1 intx, 2 message count,
    // 3 detach count, 4 last message vector
    typedef struct {
        int          kind;
        logic [15:0] exp;
        string       req;
    } item_t;

    item_t sb_q[$];
    int    checks = 0;
    int    errors = 0;
    int    msg_cnt = 0;
    int    det_cnt = 0;
    logic [15:0] last_vec = 16'h0;
    bit    done = 1'b0;

    // requirement model
    logic [15:0] m_ctl;
    logic m_btn, m_pchg, m_cmd, m_pres, m_lock, m_pend, m_intx;
    int   e_msg = 0;
    int   e_det = 0;
    logic [15:0] e_vec = 16'h0;

    function automatic logic [15:0] m_sts();
        logic [15:0] s = 16'h0;
        s[0] = m_btn; s[3] = m_pchg; s[4] = m_cmd; s[6] = m_pres; s[7] = m_lock;
        return s;
    endfunction

    // monitor: counts pulses, then pops and compares expectations
    always @(negedge clk) begin
        logic [15:0] act;
        if (msg_pulse) begin
            msg_cnt++;
            last_vec = 16'(msg_vec);
        end
        if (detach) det_cnt++;
        while (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            case (it.kind)
                0: act = cfg_rdata;
                1: act = {15'h0, intx};
                2: act = 16'(msg_cnt);
                3: act = 16'(det_cnt);
                default: act = last_vec;
            endcase
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s kind %0d actual %h expected %h", it.req, it.kind, act, it.exp);
            end
        end
    end

    task automatic settle();
        logic p;
        p = m_ctl[5] & (|(m_sts() & m_ctl & 16'h0019));
        if ((msi_en | msix_en) && p && !m_pend) begin
            e_msg++;
            e_vec = 16'(msg_vector);
        end
        m_pend = p;
        m_intx = p & ~(msi_en | msix_en);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
        end
    endtask

    task automatic push(input int kind, input logic [15:0] exp, input string req);
        item_t it;
        it.kind = kind; it.exp = exp; it.req = req;
        sb_q.push_back(it);
    endtask

    task automatic chk_all(input string req);
        cfg_sel = 1'b0;
        push(0, m_ctl, req);
        push(1, {15'h0, m_intx}, req);
        push(2, 16'(e_msg), req);
        push(3, 16'(e_det), req);
        push(4, e_vec, req);
        idle(1);
        cfg_sel = 1'b1;
        push(0, m_sts(), req);
        idle(1);
    endtask

    task automatic do_reset(input logic pop);
        rst = 1'b1;
        slot_populated = pop;
        idle(2);
        rst = 1'b0;
        m_ctl = 16'h00C0 | (pop ? 16'h0100 : 16'h0700);
        m_btn = 0; m_pchg = 0; m_cmd = 0; m_lock = 0; m_pres = pop;
        m_pend = 0; m_intx = 0;
        idle(1);
    endtask

    task automatic do_ctl(input logic [15:0] d, input logic [1:0] be);
        logic [15:0] bm;
        cfg_wr = 1'b1; cfg_sel = 1'b0; cfg_wdata = d; cfg_be = be;
        idle(1);
        cfg_wr = 1'b0; cfg_be = 2'b00;
        if (be != 2'b00) begin
            bm = {{8{be[1]}}, {8{be[0]}}} & 16'h07F9;
            if (be[1] && d[11]) m_lock = ~m_lock;
            if (be[1] && m_pres && d[10] && d[9:8] == 2'b11) begin
                m_pres = 0; m_pchg = 1; e_det++;
            end
            m_ctl = (m_ctl & ~bm) | (d & bm);
            m_cmd = 1;
        end
        settle();
        idle(2);
    endtask

    task automatic do_sts(input logic [15:0] d, input logic [1:0] be, input logic btn);
        cfg_wr = 1'b1; cfg_sel = 1'b1; cfg_wdata = d; cfg_be = be; evt_btn = btn;
        idle(1);
        cfg_wr = 1'b0; cfg_be = 2'b00; evt_btn = 1'b0;
        if (be[0]) begin
            if (d[0]) m_btn = 0;
            if (d[3]) m_pchg = 0;
            if (d[4]) m_cmd = 0;
        end
        if (btn) m_btn = 1;
        settle();
        idle(2);
    endtask

    task automatic do_evt(input logic btn, input logic add);
        evt_btn = btn; evt_add = add;
        idle(1);
        evt_btn = 1'b0; evt_add = 1'b0;
        if (btn | add) m_btn = 1;
        if (add) begin m_pres = 1; m_pchg = 1; end
        settle();
        idle(2);
    endtask

    initial begin
        #1;
        do_reset(1'b0);
        chk_all("R1");                         // empty slot reset: ctl 07C0
        do_ctl(16'h07F9, 2'b11);
        chk_all("R3");                         // enables on, cmd done, intx up
        do_sts(16'h0010, 2'b01, 1'b0);
        chk_all("R6");                         // clear drops intx
        do_evt(1'b1, 1'b0);
        chk_all("R9");                         // button sets bit 0
        do_sts(16'h0001, 2'b10, 1'b0);
        chk_all("R2");                         // wrong byte enable: no clear
        do_sts(16'h0001, 2'b01, 1'b0);
        chk_all("R2");                         // cleared
        msi_en = 1'b1;
        settle();
        idle(2);
        do_evt(1'b1, 1'b0);
        chk_all("R7");                         // message with vector 19
        do_evt(1'b1, 1'b0);
        chk_all("R8");                         // already set: no new message
        do_sts(16'h0001, 2'b01, 1'b0);
        chk_all("R7");                         // fall sends nothing
        msg_vector = 5'd7;
        do_ctl(16'h0FF9, 2'b11);
        chk_all("R4");                         // interlock engaged, bit 11 reads 0
        do_sts(16'h0010, 2'b01, 1'b0);
        do_ctl(16'h0FF9, 2'b11);
        chk_all("R4");                         // interlock released
        do_sts(16'h0010, 2'b01, 1'b0);
        do_ctl(16'h0800, 2'b01);
        chk_all("R10");                        // byte 0 only, no flip
        do_sts(16'h0010, 2'b01, 1'b0);
        do_ctl(16'h07F9, 2'b00);
        chk_all("R10");                        // no byte enable: nothing
        msi_en = 1'b0;
        settle();
        idle(2);
        do_ctl(16'h07F9, 2'b11);
        chk_all("R6");                         // level mode again
        do_sts(16'h0010, 2'b01, 1'b0);
        do_evt(1'b0, 1'b1);
        chk_all("R9");                         // hot-add
        do_sts(16'h0009, 2'b01, 1'b0);
        do_ctl(16'h05F9, 2'b11);
        chk_all("R5");                         // indicator on: no detach
        do_ctl(16'h07F9, 2'b11);
        chk_all("R5");                         // detach
        do_ctl(16'h07F9, 2'b11);
        chk_all("R5");                         // empty: no second detach
        do_sts(16'h0019, 2'b01, 1'b0);
        do_evt(1'b1, 1'b0);
        do_sts(16'h0001, 2'b01, 1'b1);
        chk_all("R2");                         // set wins over clear
        do_ctl(16'h07D9, 2'b11);
        chk_all("R6");                         // master enable off: intx low
        do_reset(1'b1);
        chk_all("R1");                         // populated reset: 01C0 / 0040
        idle(2);
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: run did not end, actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule